// File: doc/BRIEF.md
# Sorted PWM Event Schedule Builder

This block turns one colour's set of per-channel duty levels into a compact schedule for a software-style PWM frame. Rather than comparing every channel against a counter on each tick, a driver using the schedule switches all lit channels on at the start of the frame and then waits for a short list of compare points. At each point a whole group of channels turns off at once. Channels that share a duty level are merged into one group, so the list has one step per distinct level.

A one-cycle `start` captures all duty levels from a parallel bus. The block then searches repeatedly for the smallest level still active. Each search retires every channel at that level and writes the resulting step into an internal table of `NCH+1` entries. When no channel is left, the rest of the table is closed off in a single cycle and `done` pulses. The driver reads the finished table through a combinational read port: entry 0 holds the frame-start mask. Each entry holds the compare value at which the next entry's mask takes over, plus a flag saying whether that next step exists.

Top module: `sched_builder`

## Requirements
- R1: After reset, `busy` and `done` are low and every table entry reads mask 0, compare 0, flag 0.
- R2: Entry 0's mask has bit i set exactly when channel i's duty is nonzero. A channel with duty 0 is clear in every entry's mask.
- R3: Each distinct duty level L in the range 1..254 creates exactly one step, in ascending order of L. If L is the k-th smallest such level, entry k's mask holds exactly the channels whose duty exceeds L. All channels at level L therefore leave together.
- R4: For each step k (entries 1..S, where S is the number of such levels), entry k-1 holds compare value L and continue flag 1.
- R5: Channels at duty 255 create no compare point. They stay set in the mask of every entry after entry 0, including the last step's mask.
- R6: Entry S has compare 0 and flag 0, which marks the end of the schedule. Every entry above S repeats entry S's mask, with compare 0 and flag 0.
- R7: Each mask is read as two bytes. `rd_mask_lo` bit j is channel j (channels 0..7), and `rd_mask_hi` bit j is channel 8+j.
- R8: If `start` is sampled high at rising edge E while the block is idle, `done` is high for exactly one cycle following edge E+D+1. Here D is the number of distinct nonzero duty levels, so `done` comes at most NCH+1 edges after E.
- R9: The duty levels are captured at edge E. A `start` raised while `busy` is high, and any change to `duty_in` after E, leave that run's table and its single `done` pulse unchanged.
- R10: `busy` is high from the edge after E up to the edge that raises `done`, and is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a build from `duty_in` (ignored while busy) |
| duty_in | input | NCH*VW (128) | Duty levels, channel i in bits [i*VW +: VW] |
| rd_idx | input | $clog2(NCH+1) (5) | Table entry to read |
| rd_mask_lo | output | NCH/2 (8) | Mask of the addressed entry, channels 0..7 |
| rd_mask_hi | output | NCH-NCH/2 (8) | Mask of the addressed entry, channels 8..15 |
| rd_cmp | output | VW (8) | Compare value of the addressed entry |
| rd_cont | output | 1 | Continue flag of the addressed entry |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle pulse when the table is complete |

## Verification
A wrong active set or a wrong minimum shows up directly in the table: a misplaced step mask, a compare value out of order, or a merged level split into two steps. Any of these is visible on the read port as soon as `done` rises. A wrong pass count moves `done` away from its exact position at D+1 edges after the start edge. This is checked on every run, so a slip of one cycle is caught in the same run. A table-pointer error shows up in the closing entries, because the flag and the repeated mask would sit in the wrong row.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } sched_state_e;

endpackage

// File: rtl/sched_min_scan.sv
module sched_min_scan #(
  parameter int NCH = 16,
  parameter int VW  = 8
) (
  input  logic [NCH*VW-1:0] duty,
  input  logic [NCH-1:0]    active,
  output logic [VW-1:0]     min_val,
  output logic [NCH-1:0]    hit
);

  localparam logic [VW-1:0] MAXV = {VW{1'b1}};

  // Smallest level among active channels, MAXV when none is active.
  function automatic logic [VW-1:0] scan_min(input logic [NCH*VW-1:0] d,
                                             input logic [NCH-1:0] act);
    logic [VW-1:0] m;
    m = MAXV;
    for (int i = 0; i < NCH; i++) begin
      if (act[i] && (d[i*VW +: VW] < m)) m = d[i*VW +: VW];
    end
    return m;
  endfunction

  assign min_val = scan_min(duty, active);

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit[g] = active[g] && (duty[g*VW +: VW] == min_val);
  end

endmodule

// File: rtl/sched_table.sv
module sched_table #(
  parameter int NCH = 16,
  parameter int VW  = 8,
  localparam int NENT = NCH + 1,
  localparam int IW   = $clog2(NENT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_init,
  input  logic [NCH-1:0] init_mask,
  input  logic           wr_step,
  input  logic           wr_fill,
  input  logic [IW-1:0]  ptr,
  input  logic [NCH-1:0] step_mask,
  input  logic [VW-1:0]  step_cmp,
  input  logic [IW-1:0]  rd_idx,
  output logic [NCH-1:0] rd_mask,
  output logic [VW-1:0]  rd_cmp,
  output logic           rd_cont
);

  logic [NCH-1:0] ent_mask [NENT];
  logic [VW-1:0]  ent_cmp  [NENT];
  logic           ent_cont [NENT];
  logic [NCH-1:0] tail_mask;
  logic [IW:0]    ptr_next;

  assign tail_mask = (int'(ptr) < NENT) ? ent_mask[ptr] : '0;
  assign ptr_next  = {1'b0, ptr} + 1'b1;

  for (genvar k = 0; k < NENT; k++) begin : g_ent
    localparam logic [IW:0] KI = (IW+1)'(k);
    logic at_ptr, after_ptr, at_next;
    assign at_ptr    = ({1'b0, ptr} == KI);
    assign after_ptr = (KI > {1'b0, ptr});
    assign at_next   = (ptr_next == KI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_mask[k] <= '0;
        ent_cmp[k]  <= '0;
        ent_cont[k] <= 1'b0;
      end else if (wr_init) begin
        if (k == 0) ent_mask[k] <= init_mask;
      end else if (wr_step) begin
        if (at_next) ent_mask[k] <= step_mask;
        if (at_ptr) begin
          ent_cmp[k]  <= step_cmp;
          ent_cont[k] <= 1'b1;
        end
      end else if (wr_fill) begin
        if (after_ptr) ent_mask[k] <= tail_mask;
        if (at_ptr || after_ptr) begin
          ent_cmp[k]  <= '0;
          ent_cont[k] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_mask = '0;
    rd_cmp  = '0;
    rd_cont = 1'b0;
    if (int'(rd_idx) < NENT) begin
      rd_mask = ent_mask[rd_idx];
      rd_cmp  = ent_cmp[rd_idx];
      rd_cont = ent_cont[rd_idx];
    end
  end

endmodule

// File: rtl/sched_builder.sv
module sched_builder #(
  parameter int NCH = 16,
  parameter int VW  = 8,
  localparam int NENT = NCH + 1,
  localparam int IW   = $clog2(NENT),
  localparam int LO_W = NCH / 2,
  localparam int HI_W = NCH - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH*VW-1:0] duty_in,
  input  logic [IW-1:0]     rd_idx,
  output logic [LO_W-1:0]   rd_mask_lo,
  output logic [HI_W-1:0]   rd_mask_hi,
  output logic [VW-1:0]     rd_cmp,
  output logic              rd_cont,
  output logic              busy,
  output logic              done
);
  import sched_pkg::*;

  localparam logic [VW-1:0] MAXV = {VW{1'b1}};

  function automatic logic [NCH-1:0] lit_mask(input logic [NCH*VW-1:0] d);
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = |d[i*VW +: VW];
    return m;
  endfunction

  sched_state_e   state_q;
  logic [NCH*VW-1:0] duty_q;
  logic [NCH-1:0] active_q;
  logic [IW-1:0]  ptr_q;
  logic           done_q;

  // Named internal events
  logic           ev_load, ev_pass, ev_step, ev_end;
  logic [VW-1:0]  min_val;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] remain;
  logic [NCH-1:0] rd_mask;

  assign ev_load = start && (state_q == ST_IDLE);
  assign ev_pass = (state_q == ST_SCAN) && (active_q != '0);
  assign ev_end  = (state_q == ST_SCAN) && (active_q == '0);
  assign ev_step = ev_pass && (min_val != MAXV);
  assign remain  = active_q & ~hit;

  sched_min_scan #(.NCH(NCH), .VW(VW)) u_scan (
    .duty    (duty_q),
    .active  (active_q),
    .min_val (min_val),
    .hit     (hit)
  );

  sched_table #(.NCH(NCH), .VW(VW)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_init   (ev_load),
    .init_mask (lit_mask(duty_in)),
    .wr_step   (ev_step),
    .wr_fill   (ev_end),
    .ptr       (ptr_q),
    .step_mask (remain),
    .step_cmp  (min_val),
    .rd_idx    (rd_idx),
    .rd_mask   (rd_mask),
    .rd_cmp    (rd_cmp),
    .rd_cont   (rd_cont)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      duty_q   <= '0;
      active_q <= '0;
      ptr_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_load) begin
        state_q  <= ST_SCAN;
        duty_q   <= duty_in;
        active_q <= lit_mask(duty_in);
        ptr_q    <= '0;
      end else if (ev_pass) begin
        active_q <= remain;
        if (ev_step) ptr_q <= ptr_q + 1'b1;
      end else if (ev_end) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end

  assign busy       = (state_q == ST_SCAN);
  assign done       = done_q;
  assign rd_mask_lo = rd_mask[LO_W-1:0];
  assign rd_mask_hi = rd_mask[NCH-1:LO_W];

endmodule

// File: rtl/sched_builder_chk.sv
module sched_builder_chk #(
  parameter int NCH = 16,
  parameter int VW  = 8,
  localparam int IW = $clog2(NCH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           ev_pass,
  input logic           ev_end,
  input logic [NCH-1:0] active_q,
  input logic [VW-1:0]  min_val,
  input logic [IW-1:0]  ptr_q
);

  localparam logic [VW-1:0] MAXV = {VW{1'b1}};

  logic [IW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ev_end)); // R8
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= (IW+1)'(NCH + 1)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev_end) |=> busy); // R10
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ev_end) |=> (busy && ptr_q >= $past(ptr_q))); // R9
  AST_ACTIVE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pass |=> (((active_q & ~$past(active_q)) == '0) && (active_q != $past(active_q)))); // R3
  AST_CMP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pass && $past(ev_pass)) |-> (min_val > $past(min_val))); // R3
  AST_FULL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pass && min_val == MAXV) |=> (active_q == '0)); // R5
  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) <= NCH); // R6

endmodule

bind sched_builder sched_builder_chk #(.NCH(NCH), .VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .ev_pass  (ev_pass),
  .ev_end   (ev_end),
  .active_q (active_q),
  .min_val  (min_val),
  .ptr_q    (ptr_q)
);

// File: tb/sched_builder_tb.sv
module sched_builder_tb;

  localparam int NCH = 16;
  localparam int VW  = 8;
  localparam int NENT = NCH + 1;
  localparam int IW = $clog2(NENT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NCH*VW-1:0] duty_in = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0] rd_mask_lo, rd_mask_hi, rd_cmp;
  logic rd_cont, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  cur_v  [NCH];
  logic [15:0] e_mask [NENT];
  logic [7:0]  e_cmp  [NENT];
  logic        e_cont [NENT];
  int          e_dist;

  always #2 clk = ~clk;

  sched_builder #(.NCH(NCH), .VW(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .duty_in(duty_in),
    .rd_idx(rd_idx), .rd_mask_lo(rd_mask_lo), .rd_mask_hi(rd_mask_hi),
    .rd_cmp(rd_cmp), .rd_cont(rd_cont), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Expected table: walk levels upward, one step per level present.
  task automatic build_expected();
    int s;
    logic [15:0] m;
    bit present;
    s = 0;
    e_dist = 0;
    m = '0;
    for (int c = 0; c < NCH; c++) if (cur_v[c] != 0) m[c] = 1'b1;
    e_mask[0] = m;
    for (int lvl = 1; lvl <= 255; lvl++) begin
      present = 1'b0;
      for (int c = 0; c < NCH; c++) if (cur_v[c] == 8'(lvl)) present = 1'b1;
      if (present) begin
        e_dist++;
        if (lvl < 255) begin
          e_cmp[s]  = 8'(lvl);
          e_cont[s] = 1'b1;
          m = '0;
          for (int c = 0; c < NCH; c++) if (cur_v[c] > 8'(lvl)) m[c] = 1'b1;
          e_mask[s+1] = m;
          s++;
        end
      end
    end
    for (int k = s; k < NENT; k++) begin
      if (k > s) e_mask[k] = e_mask[s];
      e_cmp[k]  = '0;
      e_cont[k] = 1'b0;
    end
  endtask

  task automatic pack_duty();
    for (int c = 0; c < NCH; c++) duty_in[c*VW +: VW] = cur_v[c];
  endtask

  task automatic read_and_compare(input string tag);
    logic [15:0] got;
    for (int k = 0; k < NENT; k++) begin
      @(negedge clk);
      rd_idx = IW'(k);
      #1;
      got = {rd_mask_hi, rd_mask_lo};
      check(got == e_mask[k] && rd_cmp == e_cmp[k] && rd_cont == e_cont[k],
            $sformatf("%s entry %0d {mask,cmp,cont}", tag, k),
            {got, rd_cmp, 7'd0, rd_cont}, {e_mask[k], e_cmp[k], 7'd0, e_cont[k]});
    end
  endtask

  // Start a build, check busy through the run and the exact done position.
  task automatic run_build(input string tag);
    int n;
    int busy_bad;
    build_expected();
    @(negedge clk);
    pack_duty();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    busy_bad = 0;
    while (!done && n < 40) begin
      if (!busy) busy_bad++;
      @(negedge clk);
      n++;
    end
    check(done && n == e_dist + 2, {tag, " R8 done position"}, n, e_dist + 2);
    check(busy_bad == 0 && !busy, {tag, " R10 busy window"}, busy_bad, 0);
    read_and_compare({tag, " R3 R4 R6"});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) cur_v[c] = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    for (int c = 0; c < NCH; c++) cur_v[c] = '0;
    for (int k = 0; k < NENT; k++) begin
      e_mask[k] = '0; e_cmp[k] = '0; e_cont[k] = 1'b0;
    end
    read_and_compare("R1 reset table");
    @(negedge clk);
    rst_n = 1'b1;

    // All zero: empty schedule (R2)
    run_build("R2 all zero");

    // All full level: no compare points, mask held (R5)
    for (int c = 0; c < NCH; c++) cur_v[c] = 8'hFF;
    run_build("R5 all full");

    // All equal: one merged step (R3)
    for (int c = 0; c < NCH; c++) cur_v[c] = 8'd7;
    run_build("R3 all equal");

    // All distinct, reversed: sixteen steps
    for (int c = 0; c < NCH; c++) cur_v[c] = 8'(NCH - c);
    run_build("R3 all distinct");

    // Mixed with full level and zero (R5, R2)
    for (int c = 0; c < NCH; c++) cur_v[c] = (c % 3 == 0) ? 8'hFF : (c % 3 == 1) ? 8'd0 : 8'd40;
    run_build("R5 mixed full");

    // Byte split: channel 3 at 5, channel 12 at 9 (R7)
    for (int c = 0; c < NCH; c++) cur_v[c] = '0;
    cur_v[3] = 8'd5;
    cur_v[12] = 8'd9;
    run_build("R7 split");
    @(negedge clk);
    rd_idx = '0;
    #1;
    check(rd_mask_lo == 8'h08, "R7 low byte channel 3", rd_mask_lo, 8'h08);
    check(rd_mask_hi == 8'h10, "R7 high byte channel 12", rd_mask_hi, 8'h10);
    rd_idx = IW'(1);
    #1;
    check(rd_mask_lo == 8'h00 && rd_mask_hi == 8'h10, "R7 step 1 bytes",
          {rd_mask_hi, rd_mask_lo}, 16'h1000);

    // Restart while busy and input change are ignored (R9)
    for (int c = 0; c < NCH; c++) cur_v[c] = 8'(c * 10 + 1);
    build_expected();
    @(negedge clk);
    pack_duty();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    duty_in = {NCH{8'd3}};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int dn = 0;
      for (int t = 0; t < 60; t++) begin
        @(negedge clk);
        if (done) dn++;
      end
      check(dn == 1, "R9 single done for restarted run", dn, 1);
    end
    read_and_compare("R9 table from first values");

    // Constrained random runs
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < NCH; c++) begin
        int sel;
        sel = int'($urandom % 8);
        if (sel == 0)      cur_v[c] = 8'd0;
        else if (sel == 1) cur_v[c] = 8'hFF;
        else if (sel < 5)  cur_v[c] = 8'($urandom % 6 + 1);
        else               cur_v[c] = 8'($urandom);
      end
      run_build($sformatf("rand%0d R2 R5", r));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule